// File: doc/BRIEF.md
# Parallel Printer Port Peripheral

This block sits on the I/O side of an 8-bit microcomputer and drives a Centronics-style printer. It is reached through two port addresses on a 16-bit I/O address bus, and it decodes only part of each address.

The data/status port has two roles. A write to it latches a byte onto the printer data lines. A read of it returns the printer busy flag in the lowest bit, with every other bit forced to one.

The printer strobe does not have a port of its own. It follows one bit of a system control register that other logic owns. This block watches writes to that register and never claims them. A strobe event happens only when the watched bit changes level. On that event the busy flag is loaded from the synchronised printer busy line. While the flag is set, it is re-evaluated on every clock and drops once the printer reports ready.

Top module: `lpt_io_port`

## Requirements
- R1: The data/status port is selected when `(addr & 16'hF002) == 16'h0000`, which means the bits of 0x0FFD picked out by mask 0xF002. Aliases such as 0x0001 also select it.
- R2: The control port is selected when `(addr & 16'hF002) == 16'h1000`, which means the bits of 0x1FFD picked out by the same mask.
- R3: While `rd_en` is high and the data/status port is selected, `rd_data` is 7'b1111111 in bits 7..1 and the busy flag in bit 0. In every other cycle `rd_data` is 8'hFF.
- R4: A write to the data/status port loads `wr_data` into `prn_data` at that clock edge. All other cycles leave `prn_data` unchanged.
- R5: A control port write whose bit 4 differs from the stored strobe level copies bit 4 into `prn_strobe` at that edge. All other bits of the written value, including bit 0, have no effect.
- R6: A control port write whose bit 4 equals the stored strobe level changes neither `prn_strobe` nor the busy flag.
- R7: On a strobe change, the busy flag takes the synchronised busy input at the same edge. A status read in the next cycle therefore shows it.
- R8: While the busy flag is set, it follows the synchronised busy input on every clock and clears when that input is low. While the flag is clear, it rises only on a strobe change.
- R9: `hit` is high exactly when `rd_en` or `wr_en` is high and the data/status port is selected. Control port accesses never raise `hit`.
- R10: The asynchronous power-on reset `rst_n` clears the busy flag, the strobe level and `prn_data`.
- R11: `prn_busy` passes through a two-stage synchroniser. A fall on `prn_busy` clears a set busy flag at the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| addr | input | 16 | I/O port address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | I/O read cycle |
| wr_en | input | 1 | I/O write cycle |
| rd_data | output | 8 | Read data, status or all ones |
| hit | output | 1 | Data/status port access claimed |
| prn_data | output | 8 | Printer data lines |
| prn_strobe | output | 1 | Printer strobe level |
| prn_busy | input | 1 | Printer busy, asynchronous |

## Verification
The assertions assume the bus never raises `rd_en` and `wr_en` together. They also assume `addr` and `wr_data` are stable around the clock edge of an access, and that `prn_busy` changes only when it is far enough from an edge to be sampled cleanly. The stimulus drives every bus input on the falling edge and lowers both enables between accesses. It changes `prn_busy` only on a falling edge, then waits four idle cycles before the next access so the synchronised value is settled. The one exception is the latency test, which counts edges from the change on purpose.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned LPT_AW = 16;
  localparam int unsigned LPT_DW = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2
  } lpt_sel_e;
endpackage

// File: rtl/lpt_addr_decode.sv
module lpt_addr_decode
  import lpt_pkg::*;
#(
  parameter int unsigned      AW         = LPT_AW,
  parameter logic [AW-1:0]    DEC_MASK   = 16'hF002,
  parameter logic [AW-1:0]    DATA_PORT  = 16'h0FFD,
  parameter logic [AW-1:0]    CTRL_PORT  = 16'h1FFD
) (
  input  logic [AW-1:0] addr,
  output lpt_sel_e      sel
);
  localparam logic [AW-1:0] DATA_KEY = DATA_PORT & DEC_MASK;
  localparam logic [AW-1:0] CTRL_KEY = CTRL_PORT & DEC_MASK;

  logic [AW-1:0] masked;

  always_comb begin
    masked = addr & DEC_MASK;
    if (masked == DATA_KEY)      sel = SEL_DATA;
    else if (masked == CTRL_KEY) sel = SEL_CTRL;
    else                         sel = SEL_NONE;
  end
endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_data_latch.sv
module lpt_data_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r;
  logic [DW-1:0] q_nxt;

  always_comb q_nxt = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/lpt_strobe_busy.sv
module lpt_strobe_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  input  logic busy_sync,
  output logic strobe,
  output logic busy,
  output logic strobe_chg
);
  logic strobe_q, strobe_nxt;
  logic busy_q, busy_nxt;
  logic upd_en;

  always_comb begin
    strobe_chg = ctrl_wr && (ctrl_bit != strobe_q);
    upd_en     = strobe_chg || busy_q;
    strobe_nxt = strobe_q;
    busy_nxt   = busy_q;
    if (strobe_chg) begin
      strobe_nxt = ctrl_bit;
      busy_nxt   = busy_sync;
    end else if (busy_q) begin
      busy_nxt   = busy_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
    end else if (upd_en) begin
      strobe_q <= strobe_nxt;
      busy_q   <= busy_nxt;
    end
  end

  assign strobe = strobe_q;
  assign busy   = busy_q;
endmodule

// File: rtl/lpt_io_port.sv
module lpt_io_port
  import lpt_pkg::*;
#(
  parameter int unsigned   AW          = LPT_AW,
  parameter int unsigned   DW          = LPT_DW,
  parameter logic [AW-1:0] DEC_MASK    = 16'hF002,
  parameter logic [AW-1:0] DATA_PORT   = 16'h0FFD,
  parameter logic [AW-1:0] CTRL_PORT   = 16'h1FFD,
  parameter int unsigned   STROBE_BIT  = 4,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          wr_en,
  output logic [DW-1:0] rd_data,
  output logic          hit,
  output logic [DW-1:0] prn_data,
  output logic          prn_strobe,
  input  logic          prn_busy
);
  localparam logic [DW-2:0] STATUS_ONES = '1;

  lpt_sel_e sel;
  logic     busy_sync;
  logic     busy_flag;
  logic     strobe_chg;
  logic     data_wr;
  logic     ctrl_wr;

  lpt_addr_decode #(
    .AW(AW), .DEC_MASK(DEC_MASK), .DATA_PORT(DATA_PORT), .CTRL_PORT(CTRL_PORT)
  ) u_dec (
    .addr(addr),
    .sel (sel)
  );

  lpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (prn_busy),
    .q    (busy_sync)
  );

  always_comb begin
    data_wr = wr_en && (sel == SEL_DATA);
    ctrl_wr = wr_en && (sel == SEL_CTRL);
  end

  lpt_data_latch #(.DW(DW)) u_data (
    .clk  (clk),
    .rst_n(rst_n),
    .load (data_wr),
    .d    (wr_data),
    .q    (prn_data)
  );

  lpt_strobe_busy u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bit  (wr_data[STROBE_BIT]),
    .busy_sync (busy_sync),
    .strobe    (prn_strobe),
    .busy      (busy_flag),
    .strobe_chg(strobe_chg)
  );

  always_comb begin
    hit = (rd_en || wr_en) && (sel == SEL_DATA);
    if (rd_en && (sel == SEL_DATA)) rd_data = {STATUS_ONES, busy_flag};
    else                            rd_data = '1;
  end
endmodule

// File: rtl/lpt_io_port_chk.sv
module lpt_io_port_chk #(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DW         = 8,
  parameter logic [AW-1:0] DEC_MASK   = 16'hF002,
  parameter logic [AW-1:0] DATA_PORT  = 16'h0FFD,
  parameter logic [AW-1:0] CTRL_PORT  = 16'h1FFD,
  parameter int unsigned   STROBE_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] rd_data,
  input logic          hit,
  input logic [DW-1:0] prn_data,
  input logic          prn_strobe,
  input logic          busy_flag,
  input logic          busy_sync
);
  logic is_data, is_ctrl, chg;
  always_comb begin
    is_data = (addr & DEC_MASK) == (DATA_PORT & DEC_MASK);
    is_ctrl = (addr & DEC_MASK) == (CTRL_PORT & DEC_MASK);
    chg     = wr_en && is_ctrl && (wr_data[STROBE_BIT] != prn_strobe);
  end

  a_r4_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_data) |=> (prn_data == $past(wr_data)));
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_data) |=> $stable(prn_data));
  a_r5_strobe_follow: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (prn_strobe == $past(wr_data[STROBE_BIT])));
  a_r6_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |=> $stable(prn_strobe));
  a_r7_busy_load: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (busy_flag == $past(busy_sync)));
  a_r8_no_spurious_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !busy_flag) |=> !busy_flag);
  a_r8_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && busy_flag && !busy_sync) |=> !busy_flag);
  a_r9_ctrl_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |-> !hit);
  a_r3_status_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_data) |-> (rd_data[DW-1:1] == '1 && rd_data[0] == busy_flag));
endmodule

bind lpt_io_port lpt_io_port_chk #(
  .AW(AW), .DW(DW), .DEC_MASK(DEC_MASK), .DATA_PORT(DATA_PORT),
  .CTRL_PORT(CTRL_PORT), .STROBE_BIT(STROBE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rd_data   (rd_data),
  .hit       (hit),
  .prn_data  (prn_data),
  .prn_strobe(prn_strobe),
  .busy_flag (busy_flag),
  .busy_sync (busy_sync)
);

// File: tb/lpt_io_port_bench.sv
module lpt_io_port_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wr_data;
  logic        rd_en, wr_en;
  logic [7:0]  rd_data;
  logic        hit;
  logic [7:0]  prn_data;
  logic        prn_strobe;
  logic        prn_busy;

  int n_chk = 0;
  int n_bad = 0;

  lpt_io_port u_lpt_io_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data), .hit(hit),
    .prn_data(prn_data), .prn_strobe(prn_strobe), .prn_busy(prn_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        rd;
    logic        wr;
    logic        bsy;
    logic        e_hit;
    logic [7:0]  e_rd;
    logic [7:0]  e_dout;
    logic        e_stb;
    logic        e_busy;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h0FFD, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFE, 8'h00, 1'b0, 1'b0},
    '{16'h0FFD, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hA5, 1'b0, 1'b0},
    '{16'h1FFD, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hA5, 1'b1, 1'b1},
    '{16'h0FFD, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hA5, 1'b1, 1'b1},
    '{16'h1FFD, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 1'b1, 1'b0},
    '{16'h0001, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFE, 8'hA5, 1'b1, 1'b0},
    '{16'h1000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 1'b0, 1'b0},
    '{16'h0FFF, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 1'b0, 1'b0},
    '{16'h1FFF, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 1'b0, 1'b0},
    '{16'h1FFD, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hA5, 1'b1, 1'b1},
    '{16'h1FFD, 8'hEF, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hA5, 1'b0, 1'b1},
    '{16'h8FFD, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hA5, 1'b0, 1'b1},
    '{16'h0FFD, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h5A, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_bus();
    rd_en = 1'b0; wr_en = 1'b0; addr = 16'h0000; wr_data = 8'h00;
  endtask

  // Status read through the data/status port; busy is bit 0 (R3)
  task automatic status_read(input string req, input logic exp_busy);
    @(negedge clk);
    addr = 16'h0FFD; rd_en = 1'b1; wr_en = 1'b0;
    #2 chk(req, {8'h00, rd_data}, {8'h00, 7'h7F, exp_busy});
    @(negedge clk);
    idle_bus();
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    @(negedge clk);
    addr = 16'h1FFD; wr_data = v; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    idle_bus();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prn_busy = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    // R10: power-on state
    chk("R10 data", {8'h00, prn_data}, 16'h0000);
    chk("R10 strobe", {15'h0, prn_strobe}, 16'h0000);
    rst_n = 1'b1;
    status_read("R10 busy", 1'b0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      prn_busy = VEC[i].bsy;
      repeat (4) @(negedge clk);
      addr = VEC[i].addr; wr_data = VEC[i].wd;
      rd_en = VEC[i].rd; wr_en = VEC[i].wr;
      #2;
      chk("R1/R2/R9 hit", {15'h0, hit}, {15'h0, VEC[i].e_hit});
      chk("R3 rd_data", {8'h00, rd_data}, {8'h00, VEC[i].e_rd});
      @(posedge clk); #1;
      chk("R4 prn_data", {8'h00, prn_data}, {8'h00, VEC[i].e_dout});
      chk("R5/R6 strobe", {15'h0, prn_strobe}, {15'h0, VEC[i].e_stb});
      @(negedge clk);
      addr = 16'h0FFD; rd_en = 1'b1; wr_en = 1'b0;
      #2 chk("R7/R8 busy", {8'h00, rd_data}, {8'h00, 7'h7F, VEC[i].e_busy});
      @(negedge clk);
      idle_bus();
    end

    // R8: busy_in high without a strobe change does not set busy
    @(negedge clk); prn_busy = 1'b1;
    repeat (5) @(negedge clk);
    status_read("R8 no strobe", 1'b0);

    // R11: synchroniser latency on the falling busy input
    ctrl_write(8'h10);            // strobe 0 -> 1 with busy high
    status_read("R7 set", 1'b1);
    @(negedge clk);
    addr = 16'h0FFD; rd_en = 1'b1;
    prn_busy = 1'b0;
    @(posedge clk); #1 chk("R11 edge1", {8'h00, rd_data}, 16'h00FF);
    @(posedge clk); #1 chk("R11 edge2", {8'h00, rd_data}, 16'h00FF);
    @(posedge clk); #1 chk("R11 edge3", {8'h00, rd_data}, 16'h00FE);
    @(negedge clk); idle_bus();

    // R6: same level again leaves busy clear even with busy input high
    prn_busy = 1'b1;
    repeat (4) @(negedge clk);
    ctrl_write(8'hFF);
    chk("R6 strobe", {15'h0, prn_strobe}, 16'h0001);
    status_read("R6 busy", 1'b0);

    // R10: reset mid-run clears everything
    @(negedge clk);
    addr = 16'h0FFD; wr_data = 8'h77; wr_en = 1'b1;
    @(negedge clk); idle_bus();
    rst_n = 1'b0;
    #1;
    chk("R10 mid data", {8'h00, prn_data}, 16'h0000);
    chk("R10 mid strobe", {15'h0, prn_strobe}, 16'h0000);
    prn_busy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    status_read("R10 mid busy", 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule